// File: doc/BRIEF.md
# Dual-Mode Divider Configuration Loader

This block holds the programming word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test selector. The divide values can be set from parallel pins, which are transparent while the active-low parallel strobe is low and are captured when it rises. They can also be set from a serial port made of a clock, a data line and a load strobe. That port shifts a 14-slot frame into a shift register and moves it into the holding registers on a strobe rising edge, or on every serial clock edge while the strobe stays high.

All strobes and the serial clock are sampled by the block clock and compared with registered copies to find their edges. A TEST pin is driven through a four-way selector that the test bits control, and a flag is raised while the held feedback value is outside the range where the loop can lock. After reset, the levels on the parallel pins are taken as the configuration, so hardwired pins act as the power-up default.

Top module: `cfg_loader`

## Requirements
- R1: Reset clears the shift register and the test bits, so tsel_o is 0 and test_o is low right after reset.
- R2: While pload_ni is sampled low, m_o and n_o take m_par_i and n_par_i one clock later.
- R3: The pins sampled in the first clock with pload_ni high (including the first clock after reset) are held, and later pin changes have no effect while pload_ni stays high.
- R4: The shift register shifts sdata_i in on each sampled rising edge of sclk_i, but only while pload_ni is high; with pload_ni low, sclk_i is ignored.
- R5: A sampled rising edge of sload_i with pload_ni high loads m_o, n_o and tsel_o from the frame. In shift order the frame is T1, T0, N1, N0, M0 to M5, one discarded slot, then M6, M7, M8.
- R6: While sload_i stays high, each sclk_i rising edge loads the newly shifted frame; after sload_i falls, the held values stay frozen while shifting goes on.
- R7: test_o follows tsel_o: 0 gives low, 1 gives the oldest shift-register bit, 2 gives mdiv_i and 3 gives fout_i.
- R8: test_o is low whenever pload_ni is low.
- R9: m_range_err_o is high exactly when m_o is below 10 or above 28.
- R10: A serial load replaces captured parallel values, which stay in place until pload_ni goes low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that samples all control inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pload_ni | input | 1 | Parallel load strobe, active low |
| m_par_i | input | 9 | Parallel feedback divide value |
| n_par_i | input | 2 | Parallel output divide code |
| sload_i | input | 1 | Serial load strobe |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data bit |
| mdiv_i | input | 1 | Feedback divider output for the TEST selector |
| fout_i | input | 1 | Final output clock for the TEST selector |
| m_o | output | 9 | Held feedback divide value |
| n_o | output | 2 | Held output divide code |
| tsel_o | output | 2 | Held test selector {T1,T0} |
| test_o | output | 1 | TEST pin |
| m_range_err_o | output | 1 | Feedback value outside 10 to 28 |

## Verification
m_o, n_o and tsel_o change one block clock after the strobe level or serial clock edge that causes the change is sampled. test_o and m_range_err_o follow combinationally from the held state and from pload_ni, mdiv_i and fout_i in the same cycle. The bench changes inputs 1 ns after a rising edge and steps its reference model on the next rising edge. It compares every output at the falling edge in between, so each result is checked in exactly the cycle it is due.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int M_W    = 9;
  localparam int N_W    = 2;
  localparam int T_W    = 2;
  localparam int M_PRE  = 6;   // M bits sent before the discarded slot
  localparam int NULL_W = 1;
  localparam int FRAME_W = T_W + N_W + M_W + NULL_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  // oldest bit sits at the top; order: T msb-first, N msb-first, M lsb-first with a gap
  function automatic cfg_t frame_decode(logic [FRAME_W-1:0] f);
    cfg_t c;
    int   p;
    c = '0;
    p = FRAME_W - 1;
    for (int i = T_W - 1; i >= 0; i--) begin
      c.t[i] = f[p];
      p = p - 1;
    end
    for (int i = N_W - 1; i >= 0; i--) begin
      c.n[i] = f[p];
      p = p - 1;
    end
    for (int i = 0; i < M_W; i++) begin
      if (i == M_PRE) p = p - NULL_W;
      c.m[i] = f[p];
      p = p - 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/cfg_edge_det.sv
module cfg_edge_det #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] next_o,
  output logic         tap_o
);
  logic [W-1:0] sr_q;

  assign next_o = en_i ? {sr_q[W-2:0], din_i} : sr_q;
  assign tap_o  = sr_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= next_o;
  end
endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
  import cfg_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           par_ld_i,
  input  logic [M_W-1:0] m_par_i,
  input  logic [N_W-1:0] n_par_i,
  input  logic           ser_ld_i,
  input  cfg_t           ser_cfg_i,
  output cfg_t           cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (par_ld_i) begin
      cfg_q.m <= m_par_i;
      cfg_q.n <= n_par_i;
    end else if (ser_ld_i) begin
      cfg_q <= ser_cfg_i;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cfg_test_sel.sv
module cfg_test_sel #(
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             off_i,
  input  logic             tap_i,
  input  logic             mdiv_i,
  input  logic             fout_i,
  output logic             test_o
);
  logic [(1<<SEL_W)-1:0] src;

  always_comb begin
    src    = '0;
    src[1] = tap_i;
    src[2] = mdiv_i;
    src[3] = fout_i;
    test_o = off_i ? 1'b0 : src[sel_i];
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_pkg::*;
#(
  parameter int M_MIN = 10,
  parameter int M_MAX = 28
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pload_ni,
  input  logic [M_W-1:0] m_par_i,
  input  logic [N_W-1:0] n_par_i,
  input  logic           sload_i,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           mdiv_i,
  input  logic           fout_i,
  output logic [M_W-1:0] m_o,
  output logic [N_W-1:0] n_o,
  output logic [T_W-1:0] tsel_o,
  output logic           test_o,
  output logic           m_range_err_o
);
  localparam int ED_W = 3;
  localparam int ED_PL = 0;
  localparam int ED_SL = 1;
  localparam int ED_SC = 2;

  logic [ED_W-1:0]    rise;
  logic [FRAME_W-1:0] sr_next;
  logic               tap;
  logic               shift_en, par_ld, ser_ld;
  cfg_t               cfg;

  cfg_edge_det #(.W(ED_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({sclk_i, sload_i, pload_ni}),
    .rise_o (rise)
  );

  assign shift_en = pload_ni & rise[ED_SC];
  assign par_ld   = ~pload_ni | rise[ED_PL];
  assign ser_ld   = pload_ni & ~rise[ED_PL] &
                    (rise[ED_SL] | (sload_i & rise[ED_SC]));

  cfg_shift #(.W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (shift_en),
    .din_i  (sdata_i),
    .next_o (sr_next),
    .tap_o  (tap)
  );

  cfg_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_ld_i  (par_ld),
    .m_par_i   (m_par_i),
    .n_par_i   (n_par_i),
    .ser_ld_i  (ser_ld),
    .ser_cfg_i (frame_decode(sr_next)),
    .cfg_o     (cfg)
  );

  cfg_test_sel #(.SEL_W(T_W)) u_tsel (
    .sel_i  (cfg.t),
    .off_i  (~pload_ni),
    .tap_i  (tap),
    .mdiv_i (mdiv_i),
    .fout_i (fout_i),
    .test_o (test_o)
  );

  assign m_o    = cfg.m;
  assign n_o    = cfg.n;
  assign tsel_o = cfg.t;
  assign m_range_err_o = (int'(cfg.m) < M_MIN) || (int'(cfg.m) > M_MAX);
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pload_ni,
  input logic [M_W-1:0] m_par_i,
  input logic [N_W-1:0] n_par_i,
  input logic           sload_i,
  input logic           mdiv_i,
  input logic [M_W-1:0] m_o,
  input logic [N_W-1:0] n_o,
  input logic [T_W-1:0] tsel_o,
  input logic           test_o
);
  logic pv_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pv_q <= 1'b0;
    else         pv_q <= 1'b1;
  end

  AST_PAR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_ni |=> (m_o == $past(m_par_i)) && (n_o == $past(n_par_i))); // R2
  AST_PAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && pload_ni && $past(pload_ni) && !sload_i) |=> $stable({m_o, n_o, tsel_o})); // R3
  AST_TSEL_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_ni |=> $stable(tsel_o)); // R5
  AST_TEST_PAR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_ni |-> !test_o); // R8
  AST_TEST_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pload_ni && tsel_o == 2'd0) |-> !test_o); // R7
  AST_TEST_MDIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pload_ni && tsel_o == 2'd2) |-> (test_o == mdiv_i)); // R7
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pload_ni (pload_ni),
  .m_par_i  (m_par_i),
  .n_par_i  (n_par_i),
  .sload_i  (sload_i),
  .mdiv_i   (mdiv_i),
  .m_o      (m_o),
  .n_o      (n_o),
  .tsel_o   (tsel_o),
  .test_o   (test_o)
);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pload_n = 1'b1;
  logic [8:0] m_par = 9'd20;
  logic [1:0] n_par = 2'd1;
  logic       sload = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic       mdiv = 1'b0, fout = 1'b0;
  logic [8:0] m_o;
  logic [1:0] n_o, tsel_o;
  logic       test_o, err_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .pload_ni(pload_n), .m_par_i(m_par), .n_par_i(n_par),
    .sload_i(sload), .sclk_i(sclk), .sdata_i(sdata), .mdiv_i(mdiv), .fout_i(fout),
    .m_o(m_o), .n_o(n_o), .tsel_o(tsel_o), .test_o(test_o), .m_range_err_o(err_o)
  );

  // reference model
  int e_m = 0, e_n = 0, e_t = 0;
  bit p_pl = 0, p_sl = 0, p_sc = 0;
  bit q[$];

  function automatic void q_clear();
    q.delete();
    for (int i = 0; i < 14; i++) q.push_back(1'b0);
  endfunction

  initial q_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_m = 0; e_n = 0; e_t = 0; p_pl = 0; p_sl = 0; p_sc = 0;
      q_clear();
    end else begin
      bit pl_r, sl_r, sc_r;
      pl_r = pload_n && !p_pl;
      sl_r = sload && !p_sl;
      sc_r = sclk && !p_sc;
      if (pload_n && sc_r) begin
        q.push_back(sdata);
        void'(q.pop_front());
      end
      if (!pload_n || pl_r) begin
        e_m = m_par; e_n = n_par;
      end else if (sl_r || (sload && sc_r)) begin
        e_t = 2 * q[0] + q[1];
        e_n = 2 * q[2] + q[3];
        e_m = 0;
        for (int i = 0; i < 9; i++) e_m += (i < 6 ? q[4+i] : q[5+i]) << i;
      end
      p_pl = pload_n; p_sl = sload; p_sc = sclk;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int et;
      case (e_t)
        0: et = 0;
        1: et = q[0];
        2: et = mdiv;
        default: et = fout;
      endcase
      if (!pload_n) et = 0;
      chk("R2/R3/R10 m_o", m_o, e_m);
      chk("R2/R5 n_o", n_o, e_n);
      chk("R5/R6 tsel_o", tsel_o, e_t);
      chk("R4/R7/R8 test_o", test_o, et);
      chk("R9 range flag", err_o, (e_m < 10 || e_m > 28) ? 1 : 0);
    end
  end

  // toggling sources for the TEST selector
  initial forever begin
    repeat (3) @(posedge clk);
    #1 mdiv = ~mdiv;
  end
  initial forever begin
    repeat (5) @(posedge clk);
    #1 fout = ~fout;
  end

  task automatic step(int k = 1);
    repeat (k) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic sbit(bit b);
    sdata = b; sclk = 1'b1; step(2);
    sclk = 1'b0; step(2);
  endtask

  task automatic send_frame(int t, int n, int m);
    sbit(t[1]); sbit(t[0]); sbit(n[1]); sbit(n[0]);
    for (int i = 0; i < 6; i++) sbit(m[i]);
    sbit(1'b1);  // discarded slot
    for (int i = 6; i < 9; i++) sbit(m[i]);
  endtask

  task automatic sload_pulse();
    sload = 1'b1; step(2);
    sload = 1'b0; step(2);
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    step(3);
    at_neg(); chk("R1 tsel after reset", tsel_o, 0);
    rst_n = 1'b1;
    step(2);
    at_neg();
    chk("R1 tsel_o", tsel_o, 0);
    chk("R1 test_o", test_o, 0);
    chk("R3 power-up capture", m_o, 20);

    // parallel transparent path
    pload_n = 1'b0; m_par = 9'd5; n_par = 2'd3; step(2);
    at_neg(); chk("R2 m follows", m_o, 5); chk("R9 m=5 flagged", err_o, 1);
    m_par = 9'd10; step(1); at_neg(); chk("R9 m=10 ok", err_o, 0);
    m_par = 9'd28; step(1); at_neg(); chk("R9 m=28 ok", err_o, 0);
    m_par = 9'd29; step(1); at_neg(); chk("R9 m=29 flagged", err_o, 1);
    m_par = 9'd9;  step(1); at_neg(); chk("R9 m=9 flagged", err_o, 1);
    // sclk ignored while parallel
    for (int i = 0; i < 4; i++) sbit(1'b1);
    m_par = 9'd15; n_par = 2'd2; step(1);
    pload_n = 1'b1; step(1);
    m_par = 9'd99; n_par = 2'd0; step(3);
    at_neg(); chk("R3 held m", m_o, 15); chk("R3 held n", n_o, 2);

    // serial frame then strobe
    send_frame(0, 2, 20);
    at_neg(); chk("R10 no load before strobe", m_o, 15);
    sload_pulse();
    at_neg(); chk("R5 m", m_o, 20); chk("R5 n", n_o, 2); chk("R10 serial over parallel", tsel_o, 0);

    // transparent serial, then frozen
    sload = 1'b1; step(2);
    send_frame(1, 3, 25);
    at_neg(); chk("R6 transparent m", m_o, 25); chk("R6 transparent t", tsel_o, 1);
    sload = 1'b0; step(2);
    send_frame(2, 1, 12);
    at_neg(); chk("R6 frozen m", m_o, 25);
    sload_pulse();
    at_neg(); chk("R5 m=12", m_o, 12); chk("R7 sel mdiv", tsel_o, 2);
    step(8);

    // fout select and parallel forcing low
    send_frame(3, 0, 27);
    sload_pulse();
    at_neg(); chk("R7 sel fout", tsel_o, 3);
    step(10);
    pload_n = 1'b0; m_par = 9'd11;
    for (int i = 0; i < 6; i++) begin
      step(1); at_neg(); chk("R8 test low in parallel", test_o, 0);
    end
    pload_n = 1'b1; step(2);
    at_neg(); chk("R10 parallel back", m_o, 11); chk("R5 t kept", tsel_o, 3);

    // shift-register tap select and ignored shifting
    send_frame(1, 1, 18);
    sload_pulse();
    for (int i = 0; i < 5; i++) sbit(i[0]);
    pload_n = 1'b0;
    for (int i = 0; i < 3; i++) sbit(1'b1);
    pload_n = 1'b1; step(4);
    for (int i = 0; i < 6; i++) sbit(1'b0);
    step(4);
    at_neg();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired got=0 exp=1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule